// File: doc/BRIEF.md
# Serial Segment Display Loader

This block takes bytes from a chip-selected serial link and fills a 128-bit segment image. The image covers 32 segment columns by 4 common rows. A separate select line marks each byte as display data or as a command. Display bytes go into the image at a byte position taken from an address counter, and that counter steps forward by itself after each write. Command bytes can turn the display on or off, or move the address counter.

Everything runs on one system clock. The serial clock, serial data, chip select and the select line each pass through a two-stage synchroniser. Serial clock and chip-select edges are then found in the system domain, so the serial clock must be several times slower than the system clock. The image is put on the output only while the display is enabled; otherwise the output reads all zeros.

Top module: `serial_seg_loader`

## Requirements
- R1: The data line is sampled on each serial-clock rising edge while chip select is low. Bits arrive MSB first, so the first bit of a display byte lands in bit 8n+7 of the image and the eighth bit lands in bit 8n, where n is the byte position. A 1 bit lights its segment and a 0 bit leaves it dark.
- R2: While chip select is high, serial-clock edges are ignored. No byte is assembled, and the image and the address counter are not changed.
- R3: A high-to-low change of chip select clears the bit counter, which discards any partial byte.
- R4: The select line is looked at only at the rising edge of the eighth bit. Low there makes the byte display data and high makes it a command, whatever level the line had during bits one to seven.
- R5: Each display byte is written to image bits [8n+7:8n] at the current position n. The position then advances by one and wraps from 15 to 0.
- R6: Bytes can follow each other with chip select held low the whole time. The bit counter wraps after each eighth bit.
- R7: Command 0x01 turns the display on and command 0x00 turns it off. While the display is off, the image output is all zeros.
- R8: A command with bit 7 = 1 and bits 6:4 = 0 loads the position counter with bits 3:0. Any other command value, for example 0x42 or 0x90, has no effect.
- R9: An active-low reset clears the position counter to 0 and turns the display off. The image contents survive reset and show again once the display is turned back on.
- R10: Command bytes never change the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low chip select |
| cmd_sel | input | 1 | Byte type select: high = command, low = display data, taken at the eighth bit |
| seg_out | output | 128 | Segment image, bit 4*column+row; zero while the display is off |
| disp_en | output | 1 | Display-enable flag |

## Verification
The bench first loads a run of bytes with chip select held low. The run includes an address load to the last position, so a wrong wrap would put the following byte somewhere other than position 0. It also includes commands that must be ignored, and a design that decodes them too loosely would move the address and put the next byte in the wrong position. The directed tests then check the following:
- Clock pulses sent while chip select is high leave the target byte unchanged and the address where it was.
- A three-bit fragment cut off by chip select does not shift the next byte, because a design that kept the fragment would produce a rotated byte.
- A select line that changes during the byte is decided by its level at the eighth bit only.
- Reset clears the address and turns the display off while the image survives, and a design that cleared memory on reset would lose the old byte.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int COLS     = 32;
  localparam int ROWS     = 4;
  localparam int BYTE_W   = 8;
  localparam int MEM_BITS = COLS * ROWS;
  localparam int SLOTS    = MEM_BITS / BYTE_W;
  localparam int ADDR_W   = $clog2(SLOTS);
  localparam int CNT_W    = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] CMD_ON  = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_OFF = 8'h00;

  typedef struct packed {
    logic              valid;
    logic              is_cmd;
    logic [BYTE_W-1:0] data;
  } rx_byte_t;
endpackage

// File: rtl/segld_sync.sv
module segld_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d[g];
        s2_q <= s1_q;
      end
    end
    assign q[g] = s2_q;
  end
endmodule

// File: rtl/segld_rx.sv
module segld_rx
  import segld_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     sdata_s,
  input  logic     cs_n_s,
  input  logic     sel_s,
  output rx_byte_t rx_o
);
  logic              sclk_d_q, cs_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [BYTE_W-2:0] sh_q, sh_nxt;
  logic              rise, cs_fall, take, last_bit;

  assign rise     = sclk_s & ~sclk_d_q;
  assign cs_fall  = cs_d_q & ~cs_n_s;
  assign take     = rise & ~cs_n_s & ~cs_fall;
  assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));

  always_comb begin
    cnt_nxt = cnt_q;
    sh_nxt  = sh_q;
    if (cs_fall) begin
      cnt_nxt = '0;
    end else if (take) begin
      cnt_nxt = cnt_q + CNT_W'(1);
      sh_nxt  = {sh_q[BYTE_W-3:0], sdata_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_n_s;
      cnt_q    <= cnt_nxt;
      sh_q     <= sh_nxt;
    end
  end

  assign rx_o.valid  = take & last_bit;
  assign rx_o.is_cmd = sel_s;
  assign rx_o.data   = {sh_q, sdata_s};

  // R3: chip-select fall discards the partial byte
  assert_cs_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt_q == '0));
  // R2: counter frozen while deselected
  assert_cs_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(cnt_q));
  // R6: counter wraps after a completed byte
  assert_byte_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_o.valid |=> (cnt_q == '0));
endmodule

// File: rtl/segld_store.sv
module segld_store
  import segld_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  rx_byte_t            rx_i,
  output logic [MEM_BITS-1:0] seg_o,
  output logic                disp_en_o
);
  logic [SLOTS-1:0][BYTE_W-1:0] mem_q;
  logic [ADDR_W-1:0]            addr_q, addr_nxt;
  logic                         en_q, en_nxt;
  logic                         data_wr, cmd_wr, cmd_addr;

  assign data_wr  = rx_i.valid & ~rx_i.is_cmd;
  assign cmd_wr   = rx_i.valid & rx_i.is_cmd;
  assign cmd_addr = rx_i.data[BYTE_W-1] & (rx_i.data[BYTE_W-2:ADDR_W] == '0);

  always_comb begin
    addr_nxt = addr_q;
    en_nxt   = en_q;
    if (data_wr) begin
      addr_nxt = addr_q + ADDR_W'(1);
    end else if (cmd_wr) begin
      if (rx_i.data == CMD_ON)       en_nxt   = 1'b1;
      else if (rx_i.data == CMD_OFF) en_nxt   = 1'b0;
      else if (cmd_addr)             addr_nxt = rx_i.data[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      en_q   <= en_nxt;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic we;
    assign we = data_wr & (addr_q == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (we) mem_q[g] <= rx_i.data;
    end
  end

  assign seg_o     = en_q ? mem_q : '0;
  assign disp_en_o = en_q;

  // R5: position steps by one per display byte
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  // R5: last position wraps to zero
  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && addr_q == ADDR_W'(SLOTS - 1)) |=> (addr_q == '0));
  // R10: commands leave the image untouched
  assert_cmd_keeps_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> $stable(mem_q));
  // R7: enable command takes effect
  assert_enable_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rx_i.data == CMD_ON) |=> en_q);
  // R9: display off when leaving reset
  assert_reset_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !en_q);
endmodule

// File: rtl/serial_seg_loader.sv
module serial_seg_loader
  import segld_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                sdata,
  input  logic                cs_n,
  input  logic                cmd_sel,
  output logic [MEM_BITS-1:0] seg_out,
  output logic                disp_en
);
  logic       rst_m_q, rst_s_q;
  logic [3:0] pins_s;
  rx_byte_t   rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  segld_sync #(.W(4), .RST_VAL(4'b0010)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_q),
    .d     ({sclk, sdata, cs_n, cmd_sel}),
    .q     (pins_s)
  );

  segld_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .sclk_s  (pins_s[3]),
    .sdata_s (pins_s[2]),
    .cs_n_s  (pins_s[1]),
    .sel_s   (pins_s[0]),
    .rx_o    (rx_byte)
  );

  segld_store u_store (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .rx_i      (rx_byte),
    .seg_o     (seg_out),
    .disp_en_o (disp_en)
  );
endmodule

// File: tb/tb_serial_seg_loader.sv
module tb_serial_seg_loader;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0, sdata = 1'b0, cs_n = 1'b1, cmd_sel = 1'b0;
  logic [127:0] seg_out;
  logic         disp_en;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  serial_seg_loader dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
    .cs_n(cs_n), .cmd_sel(cmd_sel), .seg_out(seg_out), .disp_en(disp_en)
  );

  // {is_cmd, byte, chk, pos, expected byte, expected enable}
  localparam logic [22:0] VEC [11] = '{
    {1'b1, 8'h01, 1'b0, 4'd0,  8'h00, 1'b1},
    {1'b1, 8'h83, 1'b0, 4'd0,  8'h00, 1'b1},
    {1'b0, 8'hA5, 1'b1, 4'd3,  8'hA5, 1'b1},
    {1'b0, 8'h3C, 1'b1, 4'd4,  8'h3C, 1'b1},
    {1'b1, 8'h8F, 1'b1, 4'd3,  8'hA5, 1'b1},
    {1'b0, 8'h11, 1'b1, 4'd15, 8'h11, 1'b1},
    {1'b0, 8'h22, 1'b1, 4'd0,  8'h22, 1'b1},
    {1'b1, 8'h42, 1'b1, 4'd0,  8'h22, 1'b1},
    {1'b0, 8'h33, 1'b1, 4'd1,  8'h33, 1'b1},
    {1'b1, 8'h90, 1'b1, 4'd1,  8'h33, 1'b1},
    {1'b0, 8'h44, 1'b1, 4'd2,  8'h44, 1'b1}
  };

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(input int p);
    return seg_out[p*8 +: 8];
  endfunction

  task automatic send_bit(input logic b, input logic sel);
    @(negedge clk);
    sdata = b; cmd_sel = sel;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_mix(input logic [7:0] v, input logic early_sel, input logic last_sel);
    for (int i = 7; i >= 1; i--) send_bit(v[i], early_sel);
    send_bit(v[0], last_sel);
    repeat (10) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic sel);
    send_mix(v, sel, sel);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk);
    cs_n = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk1("R9 reset display off", disp_en, 1'b0);
    checks++;
    if (seg_out !== '0) begin
      errors++;
      $display("FAIL R9 reset image hidden: got %h expected 0", seg_out);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    set_cs(1'b0);

    // R6: whole table sent with chip select held low
    for (int i = 0; i < 11; i++) begin
      send_byte(VEC[i][21:14], VEC[i][22]);
      chk1($sformatf("R7/R6 vector %0d enable", i), disp_en, VEC[i][0]);
      if (VEC[i][13])
        chk8($sformatf("R1/R5/R8/R10 vector %0d slot %0d", i, VEC[i][12:9]),
             slot(int'(VEC[i][12:9])), VEC[i][8:1]);
    end

    // R2: pulses while deselected are ignored; address stays at 3
    set_cs(1'b1);
    send_byte(8'hFF, 1'b0);
    chk8("R2 slot 3 untouched", slot(3), 8'hA5);
    chk8("R2 slot 4 untouched", slot(4), 8'h3C);
    set_cs(1'b0);
    send_byte(8'h55, 1'b0);
    chk8("R2 address kept, slot 3", slot(3), 8'h55);

    // R3: partial byte discarded by chip-select fall
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    set_cs(1'b1);
    set_cs(1'b0);
    send_byte(8'h0F, 1'b0);
    chk8("R3 slot 4 clean byte", slot(4), 8'h0F);

    // R4: select taken only at the eighth bit
    send_mix(8'h01, 1'b1, 1'b0);
    chk8("R4 late-low select is data, slot 5", slot(5), 8'h01);
    chk1("R4 late-low select not a command", disp_en, 1'b1);
    send_mix(8'h00, 1'b0, 1'b1);
    chk1("R4 late-high select is command (R7 off)", disp_en, 1'b0);
    checks++;
    if (seg_out !== '0) begin
      errors++;
      $display("FAIL R7 image hidden when off: got %h expected 0", seg_out);
    end

    // R9: reset clears address and display, keeps image
    send_byte(8'h01, 1'b1);
    chk1("R7 re-enable", disp_en, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk1("R9 reset forces display off", disp_en, 1'b0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    send_byte(8'h01, 1'b1);
    chk8("R9 image kept, slot 3", slot(3), 8'h55);
    chk8("R9 image kept, slot 5", slot(5), 8'h01);
    send_byte(8'h77, 1'b0);
    chk8("R9 address cleared, slot 0", slot(0), 8'h77);
    chk8("R5 slot 1 not overwritten", slot(1), 8'h33);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule